// File: doc/BRIEF.md
# Ring-Buffer Echo and Pitch Effect

This block is a streaming audio effect built on a circular sample memory. Each time an input strobe arrives, it reads one stored sample. It blends that stored sample with the fresh one using a programmable fraction and writes the blended result back into the ring at the write position. The same blended value is also sent out. Because the output goes back into storage, every later pass around the ring carries a weaker copy, and the result is a decaying echo.

With the pitch option switched on, the read position moves at its own rate, separate from the write position. It can advance half a slot, one slot or two slots per input sample. Reading at a rate that differs from writing gives a crude pitch shift. Audible jumps occur when the read position passes the write position, and nothing smooths them.

The ring depth is a parameter. The default of 2400 slots holds 50 ms at 48 kHz. The blend fraction is an unsigned 8-bit value of n/256.

Top module: `echo_pitch_ring`

## Requirements
- R1: After reset, `out_valid` is low, `out_sample` is zero, and both ring positions are at slot 0.
- R2: `out_valid` is high for exactly one cycle, two clock cycles after each cycle in which `in_valid` is high, and is low at every other time.
- R3: The output equals floor((in·n + old·(256−n) + 128) / 256), saturated to the signed 24-bit range. Here n is `blend` (0..255) and old is the stored sample read for this input.
- R4: The output is written into the ring at the write slot, and the write slot then advances by one modulo DEPTH. With pitch off, the stored sample read for an input is therefore the output produced DEPTH inputs earlier.
- R5: A slot that has not been written since reset reads as zero, whatever the storage held before the reset.
- R6: With `pitch_en` high, the read slot advances independently of the write slot after each input. Rate code 2'b10 advances it by two slots modulo DEPTH. Rate code 2'b00 keeps each read slot for two consecutive inputs and then advances it by one; the first input after entering that code uses the current slot twice.
- R7: With `pitch_en` high, rate codes 2'b01 and 2'b11 both advance the read slot by one per input.
- R8: While `pitch_en` is low, the read slot is the write slot. When pitch mode is entered, it starts from that shared slot.
- R9: Inputs arriving with at least one idle cycle between strobes are each processed in full, including inputs whose read slot was written by the previous input.
- R10: In cycles without a strobe, `out_sample` holds its last value and no ring position moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| blend | input | 8 | Weight n/256 of the fresh sample |
| pitch_en | input | 1 | Gives the read slot its own rate |
| rd_rate | input | 2 | Read step: 00 half, 01 one, 10 two, 11 one |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed blended output sample |

## Verification
The assertions assume that `in_valid` is never high in two adjacent cycles. That gap lets each blended value reach storage before the next read, and one assertion flags any stimulus that breaks it. They also assume that `blend`, `pitch_en` and `rd_rate` change only between strobes. The bench's single sending task sets the controls together with the sample, lowers the strobe on the next cycle, and adds zero or more further idle cycles. Stimulus therefore never goes below the minimum spacing, and some runs sit exactly at it.

// File: rtl/echo_ring_pkg.sv
package echo_ring_pkg;

   // Read-step selection used in pitch mode
   typedef enum logic [1:0] {
      RATE_HALF   = 2'b00,
      RATE_UNIT   = 2'b01,
      RATE_DOUBLE = 2'b10,
      RATE_ALT    = 2'b11
   } rate_e;

   function automatic logic [1:0] rate_step(input rate_e r, input logic half_ph);
      case (r)
         RATE_HALF:   rate_step = half_ph ? 2'd1 : 2'd0;
         RATE_DOUBLE: rate_step = 2'd2;
         default:     rate_step = 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/ring_ptr_ctl.sv
module ring_ptr_ctl
   import echo_ring_pkg::*;
#(
   parameter int DEPTH = 2400,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          pitch_en,
   input  logic [1:0]    rate,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          wrapped
);

   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic          half_q, wrap_q;
   logic [1:0]    step;
   rate_e         rsel;

   assign rsel = rate_e'(rate);
   assign step = rate_step(rsel, half_q);

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_q + AW'(1);
         assign rd_nx = rd_q + AW'(step);
      end else begin : g_wrap_cmp
         logic [AW:0] ws, rs;
         assign ws    = {1'b0, wr_q} + (AW+1)'(1);
         assign rs    = {1'b0, rd_q} + (AW+1)'(step);
         assign wr_nx = (ws >= (AW+1)'(DEPTH)) ? AW'(ws - (AW+1)'(DEPTH)) : ws[AW-1:0];
         assign rd_nx = (rs >= (AW+1)'(DEPTH)) ? AW'(rs - (AW+1)'(DEPTH)) : rs[AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         half_q <= 1'b0;
         wrap_q <= 1'b0;
      end else if (adv) begin
         wr_q <= wr_nx;
         if ({1'b0, wr_q} == (AW+1)'(DEPTH - 1))
            wrap_q <= 1'b1;
         if (pitch_en) begin
            rd_q   <= rd_nx;
            half_q <= (rsel == RATE_HALF) ? ~half_q : 1'b0;
         end else begin
            rd_q   <= wr_nx;
            half_q <= 1'b0;
         end
      end
   end

   assign wr_addr = wr_q;
   assign rd_addr = pitch_en ? rd_q : wr_q;
   assign wrapped = wrap_q;

   // R4
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wr_q} < (AW+1)'(DEPTH)) && ({1'b0, rd_q} < (AW+1)'(DEPTH)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(wr_q) && $stable(rd_q)));

   // R6
   half_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && pitch_en && rsel == RATE_HALF && !half_q) |=> $stable(rd_q));

endmodule

// File: rtl/ring_store.sv
module ring_store #(
   parameter int DEPTH = 2400,
   parameter int DW    = 24,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] fill,
   input  logic          wrapped,
   output logic [DW-1:0] rd
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[wa] <= wd;
   end

   // Slots at or past the fill position have not been written since reset
   assign rd = (wrapped || (ra < fill)) ? mem[ra] : '0;

endmodule

// File: rtl/blend_mix.sv
module blend_mix #(
   parameter int DW = 24,
   parameter int CW = 8
) (
   input  logic signed [DW-1:0] fresh,
   input  logic signed [DW-1:0] old,
   input  logic        [CW-1:0] coef,
   output logic signed [DW-1:0] mixed
);

   localparam int PW = DW + CW + 3;
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CW - 1);
   localparam logic signed [PW-1:0] ONE  = PW'(1) <<< CW;
   localparam logic signed [PW-1:0] HI   = (PW'(1) <<< (DW - 1)) - PW'(1);
   localparam logic signed [PW-1:0] LO   = -(PW'(1) <<< (DW - 1));

   logic signed [PW-1:0] w_new, w_old, acc, shr;

   always_comb begin
      w_new = signed'(PW'(coef));
      w_old = ONE - w_new;
      acc   = PW'(fresh) * w_new + PW'(old) * w_old + HALF;
      shr   = acc >>> CW;
      if (shr > HI)
         mixed = HI[DW-1:0];
      else if (shr < LO)
         mixed = LO[DW-1:0];
      else
         mixed = shr[DW-1:0];
   end

endmodule

// File: rtl/echo_pitch_ring.sv
module echo_pitch_ring #(
   parameter int DEPTH = 2400,
   parameter int DW    = 24,
   parameter int CW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   input  logic        [CW-1:0] blend,
   input  logic                 pitch_en,
   input  logic        [1:0]    rd_rate,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample
);

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("DEPTH must be at least 4");
      end
      if (DW < 8 || DW > 30) begin : g_bad_dw
         $error("DW must be within 8..30");
      end
      if (CW < 1 || CW > 16) begin : g_bad_cw
         $error("CW must be within 1..16");
      end
   endgenerate

   logic [AW-1:0]        wr_addr, rd_addr, s1_addr;
   logic                 wrapped, s1_v;
   logic [DW-1:0]        rd_data;
   logic signed [DW-1:0] s1_new, s1_old, mix, mix_lo, mix_hi;

   ring_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .pitch_en (pitch_en),
      .rate     (rd_rate),
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .wrapped  (wrapped)
   );

   ring_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .we      (s1_v),
      .wa      (s1_addr),
      .wd      (mix),
      .ra      (rd_addr),
      .fill    (wr_addr),
      .wrapped (wrapped),
      .rd      (rd_data)
   );

   blend_mix #(.DW(DW), .CW(CW)) u_mix (
      .fresh (s1_new),
      .old   (s1_old),
      .coef  (blend),
      .mixed (mix)
   );

   // Stage 1: capture the fresh sample and the stored one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_new  <= '0;
         s1_old  <= '0;
         s1_addr <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_new  <= in_sample;
            s1_old  <= signed'(rd_data);
            s1_addr <= wr_addr;
         end
      end
   end

   // Stage 2: register the blended value (also written back to the ring)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= s1_v;
         if (s1_v)
            out_sample <= mix;
      end
   end

   assign mix_lo = (s1_new < s1_old) ? s1_new : s1_old;
   assign mix_hi = (s1_new < s1_old) ? s1_old : s1_new;

   // R2
   lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R9
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !in_valid);

   // R3
   mix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sample >= mix_lo && out_sample <= mix_hi));

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(s1_v) |-> $stable(out_sample));

endmodule

// File: tb/sim_echo_pitch_ring.sv
module sim_echo_pitch_ring;

   localparam int D = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [23:0] in_sample = '0;
   logic        [7:0]  blend = '0;
   logic               pitch_en = 1'b0;
   logic        [1:0]  rd_rate = 2'b01;
   logic               out_valid;
   logic signed [23:0] out_sample;

   echo_pitch_ring #(.DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .blend(blend), .pitch_en(pitch_en), .rd_rate(rd_rate),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   always #2 clk = ~clk;

   int     cyc = 0;
   int     tests = 0;
   int     fails = 0;
   bit     chk_on = 1'b0;
   bit     done = 1'b0;
   string  cur_req = "R1";
   longint last_out = 0;
   int     due_q[$];
   longint val_q[$];

   // Behavioural model state
   longint m_mem[D];
   bit     m_wrt[D];
   int     m_wr = 0, m_rd = 0;
   bit     m_half = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic model_reset();
      for (int i = 0; i < D; i++) m_wrt[i] = 1'b0;
      m_wr = 0; m_rd = 0; m_half = 1'b0; last_out = 0;
   endtask

   function automatic longint model_step(longint s, int n, bit pe, int rt);
      int     ra = pe ? m_rd : m_wr;
      longint old = m_wrt[ra] ? m_mem[ra] : 0;
      longint acc = s * n + old * (256 - n) + 128;
      longint res = acc >>> 8;
      if (res > 8388607) res = 8388607;
      if (res < -8388608) res = -8388608;
      m_mem[m_wr] = res;
      m_wrt[m_wr] = 1'b1;
      m_wr = (m_wr + 1) % D;
      if (!pe) begin
         m_rd = m_wr; m_half = 1'b0;
      end else if (rt == 0) begin
         if (m_half) m_rd = (m_rd + 1) % D;
         m_half = ~m_half;
      end else if (rt == 2) begin
         m_rd = (m_rd + 2) % D; m_half = 1'b0;
      end else begin
         m_rd = (m_rd + 1) % D; m_half = 1'b0;
      end
      return res;
   endfunction

   task automatic check(input bit ok, input longint act, input longint exp, input string what);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cyc);
      end
   endtask

   // Per-clock comparison against the model (R2 timing, R3/R4 data, R10 hold)
   always @(negedge clk) begin
      if (chk_on) begin
         if (due_q.size() > 0 && due_q[0] == cyc) begin
            check(out_valid == 1'b1, longint'(out_valid), 1, "out_valid");
            check(longint'(out_sample) == val_q[0], longint'(out_sample), val_q[0], "out_sample");
            last_out = val_q[0];
            void'(due_q.pop_front());
            void'(val_q.pop_front());
         end else begin
            check(out_valid == 1'b0, longint'(out_valid), 0, "idle out_valid");
            check(longint'(out_sample) == last_out, longint'(out_sample), last_out, "held out_sample");
         end
      end
   end

   task automatic send(input int s, input int n, input bit pe, input int rt, input int gap);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 24'(s);
      blend     = 8'(n);
      pitch_en  = pe;
      rd_rate   = 2'(rt);
      due_q.push_back(cyc + 2);
      val_q.push_back(model_step(longint'(s), n, pe, rt));
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_reset();
      chk_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      due_q.delete();
      val_q.delete();
      cur_req = "R1";
      check(out_valid == 1'b0, longint'(out_valid), 0, "reset out_valid");
      check(out_sample == 24'sd0, longint'(out_sample), 0, "reset out_sample");
      chk_on = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      do_reset();
      // R1: silent ring; 1000 at n=128 gives 500
      cur_req = "R1";
      send(1000, 128, 0, 1, 1);
      send(-1000, 128, 0, 1, 2);
      // R3: blend extremes and saturation boundaries
      cur_req = "R3";
      send(8388607, 255, 0, 1, 1);
      send(-8388608, 255, 0, 1, 1);
      send(12345, 0, 0, 1, 1);
      send(-77, 64, 0, 1, 3);
      send(300, 1, 0, 1, 1);
      send(-5, 200, 0, 1, 1);
      // R4: wrap the ring so feedback drives the stored sample
      cur_req = "R4";
      for (int i = 0; i < 2 * D + 3; i++)
         send((i * 70001) % 900000 - 450000, 32 + (i * 37) % 200, 0, 1, (i % 3 == 0) ? 0 : 2);
      // R10: long idle stretch between strobes
      cur_req = "R10";
      repeat (9) @(negedge clk);
      send(4242, 100, 0, 1, 6);
      // R6: double step, then half step
      cur_req = "R6";
      for (int i = 0; i < 12; i++) send(i * 1111 - 5000, 90, 1, 2, 1);
      for (int i = 0; i < 12; i++) send(3000 - i * 777, 150, 1, 0, 1);
      // R7: alternate unit code
      cur_req = "R7";
      for (int i = 0; i < 8; i++) send(i * 999, 77, 1, 3, 1);
      for (int i = 0; i < 4; i++) send(-i * 555, 77, 1, 1, 1);
      // R8: back to locked read slot, then pitch re-entered from shared slot
      cur_req = "R8";
      for (int i = 0; i < 6; i++) send(i * 321, 40, 0, 1, 1);
      for (int i = 0; i < 5; i++) send(i * 123, 40, 1, 2, 1);
      // R9: minimum spacing, pitch read hitting the slot just written
      cur_req = "R9";
      for (int i = 0; i < 10; i++) send(6000 - i * 1300, 120, 1, 0, 0);
      // R5: stale storage after a reset must read as silence
      do_reset();
      cur_req = "R5";
      for (int i = 0; i < 8; i++) send(1000 + i * 10, 100, 1, 2, 1);
      repeat (4) @(negedge clk);
      cur_req = "R2";
      check(due_q.size() == 0, longint'(due_q.size()), 0, "outputs delivered");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule